// File: doc/BRIEF.md
# Four-Way Set-Associative Read-Allocating Cache

This block sits between a processor load/store port and a slower word-wide memory. It holds 256 sets of four ways, one 32-bit word per way. A read looks up the set picked by the middle address bits. It compares the four stored tags at once and returns the word of the single matching way in the same cycle it is requested.

When no valid way matches, the block fetches the word from memory over a request/acknowledge port. It then writes the word into a victim way and hands the word to the processor on the acknowledge cycle. The victim is an empty way if the set has one. Otherwise a three-bit tree pseudo-LRU per set picks it.

Stores always go to memory. A store that hits also updates the cached copy. A store that misses leaves the cache contents alone.

Top module: `assoc4_cache`

## Requirements
- R1: Address bits 1:0 are ignored for lookup, bits 9:2 select the set, and bits 31:10 form the 22-bit tag. Two addresses that differ only in bits 1:0 hit the same word. Addresses that differ in any tag bit, including bit 31, are distinct lines.
- R2: A read whose tag matches a valid way in its set raises `cpu_ready` in the same cycle as `cpu_req`. It returns that way's word on `cpu_rdata` and starts no memory access.
- R3: A read miss holds `mem_req` high with `mem_we` low and a word-aligned `mem_addr` (bits 1:0 zero), unchanged until `mem_ack`. In the acknowledge cycle it raises `cpu_ready` with `cpu_rdata` equal to `mem_rdata`. A later read of the same word hits.
- R4: Reset (synchronous, active-low) clears every valid bit. An invalid way never matches, so the first read of any address after reset misses, even if it hit before reset.
- R5: On a miss in a set with at least one invalid way, the lowest-numbered invalid way is refilled. Four misses to distinct tags in an empty set therefore fill ways 0, 1, 2, 3 in order, evicting nothing.
- R6: On a miss in a full set, the victim comes from the set's tree bits b0..b2. If b0=0, the victim is way 0 when b1=0 and way 1 when b1=1. If b0=1, the victim is way 2 when b2=0 and way 3 when b2=1.
- R7: The tree bits are updated on every read hit, write hit and refill so that they point away from the accessed way. An access to way 0 or 1 sets b0=1 and sets b1 to the inverse of bit 0 of the way number. An access to way 2 or 3 clears b0 and sets b2 to the inverse of bit 0 of the way number. The other bits are left as they were. All tree bits reset to 0.
- R8: Every write makes exactly one memory access with `mem_we` high, the word-aligned address and the write data. It makes no memory read, and `cpu_ready` rises in the acknowledge cycle. A write hit updates the cached word. A write miss allocates nothing and evicts nothing.
- R9: At most one way of a set ever matches a given tag, and a hit returns the word of exactly that way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high on a read |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench fills one set through all four ways. It then drives it through a scripted sequence of hits and misses whose hit/miss outcome exposes each replacement choice.

A design that filled ways out of order, or did not update the tree on hits, would evict a different line. A later read the bench expects to hit would then go to memory. A design that cached a write miss would push out one of the four resident lines, and one of the reads that follow would miss.

Byte-offset aliasing, a tag difference only in bit 31, and a second reset followed by a read of a previously cached word each target a specific fault: wrong field slicing, or valid bits that survive reset.

// File: rtl/assoc4_cache_pkg.sv
// Package: shared constants, state encoding and pseudo-LRU helper functions
// for the four-way cache. Assumes exactly four ways (tree of three bits).
package assoc4_cache_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAYS-2:0] plru_t;
    typedef logic [WAY_W-1:0] way_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } state_t;

    // Victim named by the tree bits: b0 picks the half, b1/b2 the way inside it.
    function automatic way_t plru_pick(input plru_t b);
        if (!b[0]) return b[1] ? way_t'(1) : way_t'(0);
        else       return b[2] ? way_t'(3) : way_t'(2);
    endfunction

    // Tree bits after an access to way w, pointing away from w.
    function automatic plru_t plru_touch(input plru_t b, input way_t w);
        plru_t r;
        r = b;
        if (!w[1]) begin
            r[0] = 1'b1;
            r[1] = ~w[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~w[0];
        end
        return r;
    endfunction

    // Lowest-numbered invalid way; only meaningful when some way is invalid.
    function automatic way_t first_free(input logic [WAYS-1:0] v);
        way_t r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!v[i]) r = way_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/cache_way_store.sv
// Module: storage for one way of the cache. Holds a valid bit, a tag and a
// data word per set. Read is combinational at rd_idx; write is synchronous.
// A fill write loads tag, data and sets valid; a plain write touches data
// only. Assumes the caller never writes a non-fill word to an invalid entry.
module cache_way_store #(
    parameter int SETS   = 256,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // Valid bits: all cleared by reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en && wr_fill) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: no reset, written on fill or write hit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            if (wr_fill) tag_q[wr_idx] <= wr_tag;
        end
    end

    // Combinational read of the indexed entry.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end

endmodule

// File: rtl/cache_tag_match.sv
// Module: parallel tag compare across the four ways of one set and one-hot
// steered data select. Assumes the ways' entries are presented together.
module cache_tag_match
    import assoc4_cache_pkg::*;
#(
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAYS-1:0]   way_valid,
    input  logic [TAG_W-1:0]  way_tag  [WAYS],
    input  logic [DATA_W-1:0] way_data [WAYS],
    input  logic [TAG_W-1:0]  lk_tag,
    output logic [WAYS-1:0]   hit_vec,
    output logic              hit,
    output way_t              hit_way,
    output logic [DATA_W-1:0] hit_data
);

    // One comparator per way; an invalid way never matches.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == lk_tag);
    end

    // AND-OR data select and encoded way number from the hit vector.
    always_comb begin
        hit_data = '0;
        hit_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_data = hit_data | (way_data[w] & {DATA_W{hit_vec[w]}});
            if (hit_vec[w]) hit_way = hit_way | way_t'(w);
        end
        hit = |hit_vec;
    end

    // R9: never two matching ways in a set.
    p_hit_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/cache_plru_store.sv
// Module: per-set three-bit tree pseudo-LRU state and victim choice. The
// victim is the lowest invalid way when the set has one, otherwise the way
// the tree names. Assumes one update at most per cycle.
module cache_plru_store
    import assoc4_cache_pkg::*;
#(
    parameter int SETS   = 256,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [WAYS-1:0]  set_valid,
    output way_t             victim,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  way_t             up_way
);

    plru_t bits_q [SETS];

    // Tree bits: cleared at reset, moved away from the accessed way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
        end else if (up_en) begin
            bits_q[up_idx] <= plru_touch(bits_q[up_idx], up_way);
        end
    end

    // Victim choice for the set being looked up.
    always_comb begin
        if (&set_valid) victim = plru_pick(bits_q[rd_idx]);
        else            victim = first_free(set_valid);
    end

    // R7: after an update the tree never names the way just accessed.
    p_plru_away_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |=> plru_pick(bits_q[$past(up_idx)]) != $past(up_way));

endmodule

// File: rtl/assoc4_cache.sv
// Module: top of the four-way set-associative cache. Read hits complete in
// the request cycle; read misses refill one way from memory; writes go
// through to memory and update the cache only on a hit. Assumes the processor
// holds its request stable until cpu_ready, and memory holds mem_rdata with
// mem_ack for one cycle.
module assoc4_cache
    import assoc4_cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 256,
    localparam int OFF_W = $clog2(DATA_W / 8),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    state_t            state_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_wdata_q;

    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;

    logic [WAYS-1:0]   way_valid;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [DATA_W-1:0] way_data [WAYS];
    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    way_t              hit_way;
    logic [DATA_W-1:0] hit_data;
    way_t              victim;

    logic              rd_hit_now;
    logic              fill_done;
    logic              write_done;
    logic [WAYS-1:0]   wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              plru_en;
    way_t              plru_way;

    // Lookup address: live request while idle, latched one while busy.
    always_comb begin
        lk_addr = (state_q == ST_IDLE) ? cpu_addr : lat_addr_q;
        lk_idx  = lk_addr[OFF_W +: IDX_W];
        lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
    end

    // Per-way storage, one instance for each way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way_store #(
            .SETS  (SETS),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) way_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (lk_idx),
            .rd_valid(way_valid[w]),
            .rd_tag  (way_tag[w]),
            .rd_data (way_data[w]),
            .wr_en   (wr_en[w]),
            .wr_fill (fill_done),
            .wr_idx  (lk_idx),
            .wr_tag  (lk_tag),
            .wr_data (wr_data)
        );
    end

    cache_tag_match #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) match_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .way_valid(way_valid),
        .way_tag  (way_tag),
        .way_data (way_data),
        .lk_tag   (lk_tag),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_data (hit_data)
    );

    cache_plru_store #(
        .SETS(SETS)
    ) plru_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .set_valid(way_valid),
        .victim   (victim),
        .up_en    (plru_en),
        .up_idx   (lk_idx),
        .up_way   (plru_way)
    );

    // Completion events and array/tree write controls.
    always_comb begin
        rd_hit_now = (state_q == ST_IDLE) && cpu_req && !cpu_we && hit;
        fill_done  = (state_q == ST_FILL) && mem_ack;
        write_done = (state_q == ST_WRITE) && mem_ack;
        for (int w = 0; w < WAYS; w++) begin
            wr_en[w] = (fill_done && (victim == way_t'(w))) ||
                       (write_done && hit_vec[w]);
        end
        wr_data  = fill_done ? mem_rdata : lat_wdata_q;
        plru_en  = rd_hit_now || fill_done || (write_done && hit);
        plru_way = fill_done ? victim : hit_way;
    end

    // Control state and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        lat_addr_q  <= cpu_addr;
                        lat_wdata_q <= cpu_wdata;
                        if (cpu_we)   state_q <= ST_WRITE;
                        else if (!hit) state_q <= ST_FILL;
                    end
                end
                ST_FILL:  if (mem_ack) state_q <= ST_IDLE;
                ST_WRITE: if (mem_ack) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Processor and memory port outputs.
    always_comb begin
        cpu_ready = rd_hit_now || fill_done || write_done;
        cpu_rdata = (state_q == ST_FILL) ? mem_rdata : hit_data;
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = {lat_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata = lat_wdata_q;
    end

    // R3: a memory request and its address stay put until acknowledged.
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: an acknowledged memory access completes the processor access.
    p_ack_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |-> cpu_ready);

    // R2: a read hit starts no memory access.
    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready && !mem_req) |=> !mem_req);

    // R5: a refill never overwrites a valid way while an invalid one exists.
    p_free_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FILL) && !(&way_valid)) |-> !way_valid[victim]);

    // R8: a write access drives only a memory write.
    p_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(cpu_req && cpu_we && !mem_req)) |-> mem_we);

endmodule

// File: tb/assoc4_cache_tb_top.sv
// Bench: vector table walk over one set for replacement, writes and address
// fields, then directed reset checks. Memory is modelled with a short latency.
module assoc4_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    bit done = 1'b0;
    logic [31:0] mem_store [logic [31:0]];

    always #4 clk = ~clk;

    assoc4_cache dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        logic [31:0] k;
        k = {a[31:2], 2'b00};
        if (mem_store.exists(k)) return mem_store[k];
        return k ^ 32'hC3A5_0F1E;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: acknowledges two cycles after a request appears.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                cnt++;
                if (cnt == 2) begin
                    cnt = 0;
                    mem_ack = 1'b1;
                    chk(mem_addr[1:0] == 2'b00, "R3 aligned", mem_addr, {mem_addr[31:2], 2'b00});
                    if (mem_we) begin
                        mem_store[{mem_addr[31:2], 2'b00}] = mem_wdata;
                        n_wr++;
                    end else begin
                        mem_rdata = memval(mem_addr);
                        n_rd++;
                    end
                end
            end else begin
                cnt = 0;
            end
        end
    end

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int drd, output int dwr);
        int r0;
        int w0;
        int guard;
        r0 = n_rd;
        w0 = n_wr;
        guard = 0;
        rd = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        forever begin
            #3;
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            guard++;
            if (guard > 100) break;
            @(negedge clk);
        end
        chk(guard <= 100, "R3 completion", 32'(guard), 32'd0);
        drd = n_rd - r0;
        dwr = n_wr - w0;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    localparam int NV = 30;
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h0414, 32'h0814, 32'h0C14, 32'h1014, 32'h1414,
        32'h0814, 32'h0C14, 32'h1014, 32'h0414, 32'h1414,
        32'h0814, 32'h0C14, 32'h1014, 32'h1414, 32'h0814,
        32'h0414, 32'h0814, 32'h0814, 32'h2414, 32'h1014,
        32'h0814, 32'h1414, 32'h0414, 32'h2414, 32'h0000,
        32'h0400, 32'h0003, 32'h0401, 32'h0418, 32'h8000_0414};
    localparam bit V_WE [NV] = '{
        0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
        0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam bit V_MISS [NV] = '{
        1, 1, 1, 1, 1, 0, 0, 0, 1, 1, 0, 1, 1, 0, 0,
        1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 1, 1};
    localparam logic [31:0] V_WDATA [NV] = '{
        '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0,
        '0, 32'hDEAD_BEEF, '0, 32'h1234_5678, '0,
        '0, '0, '0, '0, '0, '0, '0, '0, '0, '0};
    // Requirement each entry's hit/miss outcome targets.
    localparam int V_REQ [NV] = '{
        5, 5, 5, 5, 6, 7, 7, 7, 6, 6, 7, 6, 6, 7, 7,
        6, 8, 8, 8, 8, 8, 8, 8, 8, 3, 3, 1, 1, 1, 1};

    // Watchdog: a hung run is a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int drd;
        int dwr;
        repeat (3) @(negedge clk);
        #1;
        chk(cpu_ready == 1'b0, "R4 reset ready", 32'(cpu_ready), 32'd0);
        chk(mem_req == 1'b0, "R4 reset mem_req", 32'(mem_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector walk: R5/R6/R7 replacement in set 5, R8 writes, R1/R3 fields.
        for (int i = 0; i < NV; i++) begin
            access(V_WE[i], V_ADDR[i], V_WDATA[i], rd, drd, dwr);
            if (V_WE[i]) begin
                chk(dwr == 1 && drd == 0, $sformatf("R%0d write access %0d", V_REQ[i], i),
                    32'(dwr), 32'd1);
                chk(memval(V_ADDR[i]) == V_WDATA[i], $sformatf("R8 memory word %0d", i),
                    memval(V_ADDR[i]), V_WDATA[i]);
            end else begin
                chk(drd == int'(V_MISS[i]) && dwr == 0,
                    $sformatf("R%0d hit/miss %0d", V_REQ[i], i), 32'(drd), 32'(V_MISS[i]));
                chk(rd == memval(V_ADDR[i]),
                    $sformatf("R%0d data %0d", V_MISS[i] ? 3 : 9, i), rd, memval(V_ADDR[i]));
            end
        end

        // R4: a second reset drops a line that hit before it.
        access(1'b0, 32'h0814, '0, rd, drd, dwr);
        chk(drd == 0, "R2 hit before reset", 32'(drd), 32'd0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 32'h0814, '0, rd, drd, dwr);
        chk(drd == 1, "R4 miss after reset", 32'(drd), 32'd1);
        chk(rd == 32'hDEAD_BEEF, "R4 refill data", rd, 32'hDEAD_BEEF);
        access(1'b0, 32'h0815, '0, rd, drd, dwr);
        chk(drd == 0 && rd == 32'hDEAD_BEEF, "R1 offset alias hit", rd, 32'hDEAD_BEEF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule